// File: doc/BRIEF.md
# Sign-Magnitude Fixed-Point Multiply-Accumulate Unit

This block multiplies two 17-bit sign-magnitude fixed-point numbers and can add the product to the result it produced last. Each number has a sign bit and an unsigned magnitude with eight integer bits and eight fraction bits. The block does not use a full-width multiplier. It holds one byte-wide multiplier and feeds it the four byte pairings of the two magnitudes, one pairing per cycle. Each partial product is scaled to the 8.8 binary point and then added to, or subtracted from, a wide two's-complement running total. The add of one pairing happens in the same cycle as the multiply of the next.

A client puts both operands on the inputs and raises `start` for one cycle. The `clear` input is sampled in that same cycle. With `clear` high the operation is a plain multiply. With `clear` low the new product is added to the previous result. Five clock edges after the accepting edge, `done` pulses. In that same cycle the sign-magnitude result and the overflow flag become valid. When the magnitude of the result does not fit in 16 bits, the result saturates and `overflow` is raised.

Top module: `sm_mac`

## Requirements
- R1: Operands and result use bit 16 as the sign (1 = negative) and bits 15:0 as an unsigned 8.8 magnitude. Split each magnitude M into a high byte Mh (bits 15:8) and a low byte Ml (bits 7:0). The product magnitude is then (Ah·Bh)·256 + Ah·Bl + Al·Bh + floor(Al·Bl / 256).
- R2: When `clear` is 1 at an accepted start, the result is the signed product alone. Its sign is the XOR of the operand signs. A zero magnitude is always given a sign of 0.
- R3: When `clear` is 0 at an accepted start, the signed product is added to the signed value of the previous result `z`.
- R4: When the magnitude of the signed sum exceeds 0xFFFF, `overflow` is 1 and `z` is {sign of the sum, 0xFFFF}. Otherwise `overflow` is 0. Both keep their values until the next completion.
- R5: `start` is accepted on a rising edge while the unit is idle. On the fifth rising edge after that, `done` goes to 1 for exactly one cycle, and `z` and `overflow` take their new values on that same edge.
- R6: A `start` seen on any edge from the accepting edge up to and including the completing edge is ignored. It changes neither the running result nor `z`, and it starts no further operation.
- R7: After reset, `z` is 0, `done` is 0 and `overflow` is 0, so an accumulate issued first adds to zero.
- R8: The lowest fraction byte of the low-by-low pairing is dropped before summing. This truncates the product magnitude toward zero. An operand of negative zero (0x10000) behaves as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request an operation; sampled while idle |
| clear | input | 1 | Sampled with start: 1 = plain multiply, 0 = accumulate |
| a | input | 17 | Operand A, sign-magnitude 8.8 |
| b | input | 17 | Operand B, sign-magnitude 8.8 |
| z | output | 17 | Result, sign-magnitude 8.8 |
| done | output | 1 | One-cycle pulse when z is updated |
| overflow | output | 1 | Result magnitude saturated at last completion |

## Verification
The hardest situations to reach are accumulation chains that cross the saturation point, and start requests that land on the very edge where an operation completes. A chain of accumulates is built deliberately, reaching 0xFFFE and then crossing it, and a later product of opposite sign brings the value back from the saturated magnitude. In a separate sequence, start stays high with different operands and a plain-multiply request from the accepting edge through the done edge. The bench then confirms that the first result stands and that no second done pulse follows.

// File: rtl/sm_mac_pkg.sv
package sm_mac_pkg;
  // Order of byte pairings fed to the shared multiplier.
  typedef enum logic [1:0] {
    PASS_HH = 2'd0,
    PASS_HL = 2'd1,
    PASS_LH = 2'd2,
    PASS_LL = 2'd3
  } pass_e;
endpackage

// File: rtl/sm_mac_ctrl.sv
module sm_mac_ctrl
  import sm_mac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  last_acc,
  output logic  accept,
  output logic  busy,
  output logic  issue_vld,
  output pass_e issue_pass
);
  logic       busy_q, busy_d;
  logic       iss_q, iss_d;
  pass_e      cnt_q, cnt_d;
  logic [1:0] cnt_inc;

  always_comb begin
    accept  = start & ~busy_q;
    busy_d  = busy_q;
    iss_d   = iss_q;
    cnt_d   = cnt_q;
    cnt_inc = cnt_q + 2'd1;
    if (accept) begin
      busy_d = 1'b1;
      iss_d  = 1'b1;
      cnt_d  = PASS_HH;
    end else begin
      if (iss_q) begin
        cnt_d = pass_e'(cnt_inc);
        if (cnt_q == PASS_LL) iss_d = 1'b0;
      end
      if (last_acc) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      iss_q  <= 1'b0;
      cnt_q  <= PASS_HH;
    end else begin
      busy_q <= busy_d;
      iss_q  <= iss_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy       = busy_q;
  assign issue_vld  = iss_q;
  assign issue_pass = cnt_q;

  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_q && iss_q && cnt_q == PASS_HH));

  assert_four_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_q && cnt_q == PASS_LL) |=> !iss_q);

  assert_idle_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_acc |=> !busy_q);
endmodule

// File: rtl/sm_mac_mul.sv
module sm_mac_mul
  import sm_mac_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  issue_vld,
  input  pass_e                 issue_pass,
  input  logic [2*HALF_W-1:0]   mag_a,
  input  logic [2*HALF_W-1:0]   mag_b,
  output logic                  prod_vld,
  output pass_e                 prod_pass,
  output logic [2*HALF_W-1:0]   prod
);
  localparam int PW = 2 * HALF_W;

  logic [HALF_W-1:0] op_a, op_b;
  logic [PW-1:0]     prod_d, prod_q;
  logic              vld_q;
  pass_e             pass_q, pass_d;

  always_comb begin
    op_a   = (issue_pass == PASS_HH || issue_pass == PASS_HL) ?
             mag_a[PW-1:HALF_W] : mag_a[HALF_W-1:0];
    op_b   = (issue_pass == PASS_HH || issue_pass == PASS_LH) ?
             mag_b[PW-1:HALF_W] : mag_b[HALF_W-1:0];
    prod_d = issue_vld ? (PW'(op_a) * PW'(op_b)) : prod_q;
    pass_d = issue_vld ? issue_pass : pass_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      pass_q <= PASS_HH;
      vld_q  <= 1'b0;
    end else begin
      prod_q <= prod_d;
      pass_q <= pass_d;
      vld_q  <= issue_vld;
    end
  end

  assign prod_vld  = vld_q;
  assign prod_pass = pass_q;
  assign prod      = prod_q;

  assert_pass_chain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && pass_q != PASS_LL) |=> (vld_q && pass_q != PASS_HH));
endmodule

// File: rtl/sm_mac_acc.sv
module sm_mac_acc
  import sm_mac_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic                  clear,
  input  logic                  prod_vld,
  input  pass_e                 prod_pass,
  input  logic [2*HALF_W-1:0]   prod,
  input  logic                  prod_neg,
  output logic [2*HALF_W:0]     z,
  output logic                  done,
  output logic                  overflow
);
  localparam int MW    = 2 * HALF_W;
  localparam int ACC_W = 3 * HALF_W + 3;

  logic signed [ACC_W-1:0] total_q, total_d;
  logic signed [ACC_W-1:0] base, scaled, term, sum, sum_mag;
  logic        [ACC_W-1:0] zmag_ext;
  logic        [MW:0]      z_q, z_d;
  logic        [MW-1:0]    mag_out;
  logic                    done_q, ovf_q, ovf_d, ovf_now, sum_neg, last;

  always_comb begin
    zmag_ext = ACC_W'(z_q[MW-1:0]);
    if (clear)       base = '0;
    else if (z_q[MW]) base = -$signed(zmag_ext);
    else              base = $signed(zmag_ext);

    unique case (prod_pass)
      PASS_HH: scaled = $signed(ACC_W'(prod) << HALF_W);
      PASS_HL: scaled = $signed(ACC_W'(prod));
      PASS_LH: scaled = $signed(ACC_W'(prod));
      PASS_LL: scaled = $signed(ACC_W'(prod >> HALF_W));
      default: scaled = '0;
    endcase
    term    = prod_neg ? -scaled : scaled;
    sum     = total_q + term;
    sum_neg = sum[ACC_W-1];
    sum_mag = sum_neg ? -sum : sum;
    ovf_now = (sum_mag[ACC_W-1:MW] != '0);
    mag_out = ovf_now ? '1 : sum_mag[MW-1:0];
    last    = prod_vld && (prod_pass == PASS_LL);

    if (accept)        total_d = base;
    else if (prod_vld) total_d = sum;
    else               total_d = total_q;

    z_d   = last ? {sum_neg, mag_out} : z_q;
    ovf_d = last ? ovf_now : ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      z_q     <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      total_q <= total_d;
      z_q     <= z_d;
      ovf_q   <= ovf_d;
      done_q  <= last;
    end
  end

  assign z        = z_q;
  assign done     = done_q;
  assign overflow = ovf_q;

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_after_ll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(prod_vld) && $past(prod_pass) == PASS_LL));

  assert_no_neg_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (z_q[MW-1:0] == '0) |-> !z_q[MW]);

  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (&z_q[MW-1:0]));

  assert_z_only_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(z_q) || $past(!rst_n));
endmodule

// File: rtl/sm_mac.sv
module sm_mac
  import sm_mac_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                clear,
  input  logic [2*HALF_W:0]   a,
  input  logic [2*HALF_W:0]   b,
  output logic [2*HALF_W:0]   z,
  output logic                done,
  output logic                overflow
);
  localparam int MW = 2 * HALF_W;

  logic          rst_meta_q, rst_sync_q, rst_i;
  logic          accept, busy, issue_vld, prod_vld, last_acc;
  pass_e         issue_pass, prod_pass;
  logic [MW:0]   a_q, b_q, a_d, b_d;
  logic [MW-1:0] prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_i = rst_sync_q;

  always_comb begin
    a_d = accept ? a : a_q;
    b_d = accept ? b : b_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign last_acc = prod_vld && (prod_pass == PASS_LL);

  sm_mac_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i),
    .start      (start),
    .last_acc   (last_acc),
    .accept     (accept),
    .busy       (busy),
    .issue_vld  (issue_vld),
    .issue_pass (issue_pass)
  );

  sm_mac_mul #(.HALF_W(HALF_W)) u_mul (
    .clk        (clk),
    .rst_n      (rst_i),
    .issue_vld  (issue_vld),
    .issue_pass (issue_pass),
    .mag_a      (a_q[MW-1:0]),
    .mag_b      (b_q[MW-1:0]),
    .prod_vld   (prod_vld),
    .prod_pass  (prod_pass),
    .prod       (prod)
  );

  sm_mac_acc #(.HALF_W(HALF_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_i),
    .accept    (accept),
    .clear     (clear),
    .prod_vld  (prod_vld),
    .prod_pass (prod_pass),
    .prod      (prod),
    .prod_neg  (a_q[MW] ^ b_q[MW]),
    .z         (z),
    .done      (done),
    .overflow  (overflow)
  );

  assert_ops_hold_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && start) |=> ($stable(a_q) && $stable(b_q)));

  assert_busy_until_done_R5: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(done) |-> $past(busy));
endmodule

// File: tb/sm_mac_bench.sv
module sm_mac_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, start, clear;
  logic [16:0] a, b, z;
  logic        done, overflow;

  int total = 0;
  int bad   = 0;
  logic [16:0] exp_z = '0;
  logic        exp_ovf = 1'b0;

  sm_mac u_sm_mac (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
    .a(a), .b(b), .z(z), .done(done), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Reference arithmetic taken from the requirements.
  task automatic calc(input logic [16:0] x, input logic [16:0] y, input logic clr);
    longint ah = longint'(x[15:8]);
    longint al = longint'(x[7:0]);
    longint bh = longint'(y[15:8]);
    longint bl = longint'(y[7:0]);
    longint p  = ah * bh * 256 + ah * bl + al * bh + (al * bl) / 256;
    longint base, sum, mag;
    if (clr) base = 0;
    else base = exp_z[16] ? -longint'(exp_z[15:0]) : longint'(exp_z[15:0]);
    if (x[16] ^ y[16]) p = -p;
    sum = base + p;
    mag = (sum < 0) ? -sum : sum;
    exp_ovf = (mag > 65535);
    exp_z   = {sum < 0, exp_ovf ? 16'hFFFF : mag[15:0]};
  endtask

  // Entered and left on a falling edge.
  task automatic run_op(input logic [16:0] x, input logic [16:0] y, input logic clr);
    string req = clr ? "R2" : "R3";
    bit early = 1'b0;
    calc(x, y, clr);
    a = x; b = y; clear = clr; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      if (done) early = 1'b1;
    end
    chk(!early, "R5 early done", early, 0);
    @(posedge clk); @(negedge clk);
    chk(done == 1'b1, "R5 done at fifth edge", done, 1);
    chk(z == exp_z, req, z, exp_z);
    chk(overflow == exp_ovf, "R4 overflow", overflow, exp_ovf);
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0, "R5 pulse width", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] vals [6];
    logic [31:0] rs;
    logic [16:0] held;
    bit extra;
    vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h55;
    vals[3] = 8'h80; vals[4] = 8'hAA; vals[5] = 8'hFF;

    rst_n = 1'b0; start = 1'b0; clear = 1'b0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    chk(z == 17'h0 && done == 1'b0 && overflow == 1'b0, "R7 in reset", {z, done, overflow}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(z == 17'h0 && done == 1'b0 && overflow == 1'b0, "R7 after release", {z, done, overflow}, 0);

    // R7: first accumulate adds to zero.
    run_op(17'h00300, 17'h00200, 1'b0);
    chk(z == 17'h00600, "R7 accumulate from zero", z, 17'h00600);

    // R8 truncation and negative zero.
    run_op(17'h10001, 17'h00001, 1'b1);
    chk(z == 17'h00000, "R8 tiny product is plus zero", z, 0);
    run_op(17'h00080, 17'h00080, 1'b1);
    chk(z == 17'h00040, "R8 half times half", z, 17'h40);
    run_op(17'h10000, 17'h00200, 1'b0);
    chk(z == 17'h00040, "R8 negative zero operand", z, 17'h40);

    // R4 saturation both signs, accumulate chain, recovery.
    run_op(17'h0FFFF, 17'h0FFFF, 1'b1);
    chk(z == 17'h0FFFF && overflow, "R4 max times max", z, 17'h0FFFF);
    run_op(17'h1FFFF, 17'h0FFFF, 1'b1);
    chk(z == 17'h1FFFF && overflow, "R4 negative saturate", z, 17'h1FFFF);
    run_op(17'h07FFF, 17'h00100, 1'b1);
    run_op(17'h07FFF, 17'h00100, 1'b0);
    chk(z == 17'h0FFFE && !overflow, "R4 chain below limit", z, 17'h0FFFE);
    run_op(17'h00002, 17'h00100, 1'b0);
    chk(z == 17'h0FFFF && overflow, "R4 chain crosses limit", z, 17'h0FFFF);
    run_op(17'h10100, 17'h00100, 1'b0);
    chk(z == 17'h0FEFF && !overflow, "R4 recovery clears flag", z, 17'h0FEFF);

    // R6: start held with other operands from accept through done.
    calc(17'h00280, 17'h10300, 1'b1);
    a = 17'h00280; b = 17'h10300; clear = 1'b1; start = 1'b1;
    @(posedge clk); @(negedge clk);
    a = 17'h0FFFF; b = 17'h0FFFF; clear = 1'b1;
    for (int i = 0; i < 5; i++) begin @(posedge clk); @(negedge clk); end
    chk(done == 1'b1 && z == exp_z, "R6 first result stands", z, exp_z);
    start = 1'b0;
    held = z; extra = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); @(negedge clk);
      if (done || z != held) extra = 1'b1;
    end
    chk(!extra, "R6 no second operation", extra, 0);

    // R1/R2/R3: structured sweep over byte values, signs and modes.
    for (int i = 0; i < 1296; i++) begin
      logic [16:0] x, y;
      x = {1'(i[0] ^ i[3]), vals[i % 6], vals[(i / 6) % 6]};
      y = {1'(i[1]), vals[(i / 36) % 6], vals[(i / 216) % 6]};
      run_op(x, y, (i % 3) != 0);
    end

    // R1: pseudo-random operands.
    rs = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      logic [16:0] x, y;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      x = rs[16:0];
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      y = {rs[16], rs[15:0] >> rs[19:17]};
      run_op(x, y, rs[31:30] != 2'b00);
    end
    chk(1'b1, "R1 sweep complete", 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule